// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Generator with Current Sharing

This block drives the gate enables of a two-phase synchronous buck stage from a digital control word. A single free-running counter yields two sawtooth ramps that sit half a period apart, so the two phases switch in turn rather than together. Each phase turns its high-side switch on while the effective control value lies above that phase's ramp. The effective control value is the smaller of the loop control word and the soft-start word. The high side is always forced off in the last quarter of each phase period. Every change between high side and low side passes through a programmable interval with both switches off.

One current-sense input serves both phases. The block drives a select line to steer an external multiplexer, and it pulses a capture strobe near the end of each phase period, while that phase's low side is still conducting. The two held samples are subtracted. The scaled and clamped difference lifts the ramp of the phase carrying more current and lowers the ramp of the other by the same amount, so duty moves from the heavier phase to the lighter one.

A global gate-off input shuts every switch. A soft-start word below the ramp floor does the same.

Top module: `dual_phase_pwm`

## Requirements
- R1: The phase-2 ramp equals the phase-1 ramp shifted by half of the 2^CW-count period. The capture strobes for the two phases therefore alternate exactly 2^(CW-1) cycles apart.
- R2: With the gates active and the inputs held steady, the per-period high-side on-time of phase p is max(0, N - D - 1) cycles. Here N = clamp(E - FLOOR - O_p, 0, MAXON), E is the effective control value, O_p is that phase's ramp offset and D is `dead_cfg`.
- R3: MAXON is three quarters of the period (192 counts by default). The high side of a phase is never on at that phase's capture strobe.
- R4: `sense_strobe` is high for exactly one cycle when the ramp of the phase being sampled equals 2^CW - 2. The value on `isense` in that cycle is held as that phase's sample. The sampled phase's low side is on during the strobe.
- R5: `sense_sel` = 0 selects phase 1 and `sense_sel` = 1 selects phase 2. It is 1 while the counter is in its lower half and 0 in its upper half, and it does not change in the cycle after a strobe.
- R6: The phase-1 offset is O_1 = clamp((S1 - S2) >>> GAIN_SHIFT, -OFS_LIM, +OFS_LIM), using an arithmetic shift that rounds toward minus infinity. The phase-2 offset is O_2 = -O_1. The offset is updated in the cycle after each capture, so equal samples give no offset.
- R7: The effective control value E is min(`ctrl_word`, `ss_word`).
- R8: While `gate_off` = 1 or `ss_word` < FLOOR, all four gate enables are 0 from the next clock edge onward.
- R9: The high-side and low-side enables of one phase are never both 1. Before either enable rises, both enables stay 0 for at least `dead_cfg` + 1 cycles.
- R10: During reset all gate enables and `sense_strobe` are 0, and `sense_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | CW | Loop control word |
| ss_word | input | CW | Soft-start clamp word |
| isense | input | SW | Shared current-sense sample (unsigned) |
| gate_off | input | 1 | Forces all gates off |
| dead_cfg | input | DW | Dead-time length in cycles, minus one |
| hs_en | output | 2 | High-side enables, bit 0 = phase 1 |
| ls_en | output | 2 | Low-side enables, bit 0 = phase 1 |
| sense_sel | output | 1 | Sense multiplexer select (0 = phase 1) |
| sense_strobe | output | 1 | Capture strobe for the selected phase |

## Verification
Some properties are checked by assertions on every cycle. These are the exclusion of high side and low side within a phase, the absence of any enable rising straight out of its partner, the shutdown one edge after gate-off or a low soft-start word, the single-cycle strobe with a stable select, the high side off at capture, and the offset staying inside its clamp. Other properties can only be seen in the bench's scenarios, because they need whole periods of steady inputs. These are the exact on-time per period under balanced, skewed and clamped currents, the limits from the maximum duty and the soft-start word, the half-period spacing of the captures, and the full length of the dead time.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  typedef enum logic [1:0] {
    GATE_OFF  = 2'd0,
    GATE_HIGH = 2'd1,
    GATE_LOW  = 2'd2
  } gate_state_e;

  localparam int NUM_PH = 2;
endpackage

// File: rtl/dpp_ramp_gen.sv
// Shared period counter: two interleaved ramps, sense select and capture strobe.
module dpp_ramp_gen #(
  parameter int CW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [1:0][CW-1:0]  ramp_o,
  output logic                sel_o,
  output logic                strobe_o
);
  localparam int              HALF   = 2 ** (CW - 1);
  localparam logic [CW-2:0]   STB_AT = (CW-1)'(HALF - 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Phase 2 ramp is the counter advanced by half a period.
  assign ramp_o[0] = cnt_q;
  assign ramp_o[1] = {~cnt_q[CW-1], cnt_q[CW-2:0]};

  // In the lower half phase 2 approaches its capture point, in the upper half phase 1.
  assign sel_o    = ~cnt_q[CW-1];
  assign strobe_o = (cnt_q[CW-2:0] == STB_AT);
endmodule

// File: rtl/dpp_balance.sv
// Holds one sample per phase and derives the clamped ramp offset for phase 1.
module dpp_balance #(
  parameter int SW      = 8,
  parameter int OW      = 5,
  parameter int GSH     = 2,
  parameter int OFS_LIM = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe_i,
  input  logic                 sel_i,
  input  logic [SW-1:0]        isense_i,
  output logic signed [OW-1:0] ofs_o
);
  localparam logic signed [SW:0] LIM_P = (SW+1)'(OFS_LIM);
  localparam logic signed [SW:0] LIM_N = -LIM_P;

  logic [1:0][SW-1:0]   samp_q, samp_d;
  logic                 upd_q, upd_d;
  logic signed [OW-1:0] ofs_q, ofs_d;
  logic signed [SW:0]   diff, shf;

  always_comb begin
    samp_d = samp_q;
    if (strobe_i) samp_d[sel_i] = isense_i;
    upd_d = strobe_i;
  end

  assign diff = $signed({1'b0, samp_q[0]}) - $signed({1'b0, samp_q[1]});
  assign shf  = diff >>> GSH;

  always_comb begin
    ofs_d = ofs_q;
    if (upd_q) begin
      if (shf > LIM_P)      ofs_d = LIM_P[OW-1:0];
      else if (shf < LIM_N) ofs_d = LIM_N[OW-1:0];
      else                  ofs_d = shf[OW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      upd_q  <= 1'b0;
      ofs_q  <= '0;
    end else begin
      samp_q <= samp_d;
      upd_q  <= upd_d;
      ofs_q  <= ofs_d;
    end
  end

  assign ofs_o = ofs_q;
endmodule

// File: rtl/dpp_phase_gate.sv
// One phase: ramp comparison, duty limit and dead-time sequencing of the gate pair.
module dpp_phase_gate
  import dpp_pkg::*;
#(
  parameter int CW     = 8,
  parameter int OW     = 5,
  parameter int DW     = 4,
  parameter int FLOOR  = 16,
  parameter int MAX_ON = 192
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        ramp_i,
  input  logic [CW-1:0]        eff_i,
  input  logic signed [OW-1:0] ofs_i,
  input  logic                 blank_i,
  input  logic [DW-1:0]        dead_i,
  output logic                 hs_o,
  output logic                 ls_o
);
  localparam int            AW       = CW + 2;
  localparam logic [CW-1:0] MAX_ON_V = CW'(MAX_ON);

  logic signed [AW-1:0] ramp_adj, eff_w;
  logic                 demand;
  gate_state_e          st_q, st_d;
  logic [DW-1:0]        dc_q, dc_d;

  assign ramp_adj = $signed({2'b00, ramp_i}) + $signed(AW'(FLOOR))
                  + $signed({{(AW-OW){ofs_i[OW-1]}}, ofs_i});
  assign eff_w    = $signed({2'b00, eff_i});
  assign demand   = (ramp_i < MAX_ON_V) && (eff_w > ramp_adj);

  always_comb begin
    st_d = st_q;
    dc_d = dc_q;
    if (blank_i) begin
      st_d = GATE_OFF;
      dc_d = dead_i;
    end else begin
      unique case (st_q)
        GATE_HIGH: if (!demand) begin
          st_d = GATE_OFF;
          dc_d = dead_i;
        end
        GATE_LOW: if (demand) begin
          st_d = GATE_OFF;
          dc_d = dead_i;
        end
        default: begin
          if (dc_q == '0) st_d = demand ? GATE_HIGH : GATE_LOW;
          else            dc_d = dc_q - DW'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= GATE_OFF;
      dc_q <= '0;
    end else begin
      st_q <= st_d;
      dc_q <= dc_d;
    end
  end

  assign hs_o = (st_q == GATE_HIGH);
  assign ls_o = (st_q == GATE_LOW);
endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm
  import dpp_pkg::*;
#(
  parameter int CW         = 8,
  parameter int SW         = 8,
  parameter int DW         = 4,
  parameter int FLOOR      = 16,
  parameter int OFS_LIM    = 15,
  parameter int GAIN_SHIFT = 2,
  parameter int MAX_QTR    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctrl_word,
  input  logic [CW-1:0] ss_word,
  input  logic [SW-1:0] isense,
  input  logic          gate_off,
  input  logic [DW-1:0] dead_cfg,
  output logic [1:0]    hs_en,
  output logic [1:0]    ls_en,
  output logic          sense_sel,
  output logic          sense_strobe
);
  localparam int OW     = $clog2(OFS_LIM + 1) + 1;
  localparam int PERIOD = 2 ** CW;
  localparam int MAX_ON = (PERIOD * MAX_QTR) / 4;

  logic [1:0][CW-1:0]   ramp;
  logic [CW-1:0]        eff;
  logic                 blank;
  logic signed [OW-1:0] ofs_p1;
  logic signed [OW-1:0] ofs_ph [NUM_PH];

  assign eff   = (ctrl_word < ss_word) ? ctrl_word : ss_word;
  assign blank = gate_off || (ss_word < CW'(FLOOR));

  dpp_ramp_gen #(.CW(CW)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ramp_o   (ramp),
    .sel_o    (sense_sel),
    .strobe_o (sense_strobe)
  );

  dpp_balance #(.SW(SW), .OW(OW), .GSH(GAIN_SHIFT), .OFS_LIM(OFS_LIM)) u_bal (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (sense_strobe),
    .sel_i    (sense_sel),
    .isense_i (isense),
    .ofs_o    (ofs_p1)
  );

  // Heavier phase gets its ramp raised, the other lowered by the same amount.
  assign ofs_ph[0] = ofs_p1;
  assign ofs_ph[1] = -ofs_p1;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    dpp_phase_gate #(
      .CW(CW), .OW(OW), .DW(DW), .FLOOR(FLOOR), .MAX_ON(MAX_ON)
    ) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .ramp_i  (ramp[p]),
      .eff_i   (eff),
      .ofs_i   (ofs_ph[p]),
      .blank_i (blank),
      .dead_i  (dead_cfg),
      .hs_o    (hs_en[p]),
      .ls_o    (ls_en[p])
    );
  end
endmodule

// File: rtl/dual_phase_pwm_chk.sv
module dual_phase_pwm_chk #(
  parameter int CW      = 8,
  parameter int OW      = 5,
  parameter int FLOOR   = 16,
  parameter int OFS_LIM = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           hs_en,
  input logic [1:0]           ls_en,
  input logic                 gate_off,
  input logic [CW-1:0]        ss_word,
  input logic                 sense_sel,
  input logic                 sense_strobe,
  input logic signed [OW-1:0] ofs
);
  for (genvar g = 0; g < 2; g++) begin : g_pair
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en[g] && ls_en[g]));
    p_hs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en[g]) |-> $past(!ls_en[g] && !hs_en[g]));
    p_ls_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en[g]) |-> $past(!ls_en[g] && !hs_en[g]));
  end

  p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_off || (ss_word < CW'(FLOOR))) |=> (hs_en == 2'b00 && ls_en == 2'b00));

  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sense_strobe |=> !sense_strobe);

  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sense_strobe |=> $stable(sense_sel));

  p_hs_off_at_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sense_strobe |-> !hs_en[sense_sel]);

  p_ofs_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs <= OW'(OFS_LIM)) && (ofs >= -OW'(OFS_LIM)));
endmodule

bind dual_phase_pwm dual_phase_pwm_chk #(
  .CW(CW), .OW(OW), .FLOOR(FLOOR), .OFS_LIM(OFS_LIM)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hs_en        (hs_en),
  .ls_en        (ls_en),
  .gate_off     (gate_off),
  .ss_word      (ss_word),
  .sense_sel    (sense_sel),
  .sense_strobe (sense_strobe),
  .ofs          (ofs_p1)
);

// File: tb/dual_phase_pwm_bench.sv
module dual_phase_pwm_bench;
  localparam int CW = 8, SW = 8, DW = 4;
  localparam int PERIOD = 256, HALF = 128;
  localparam int FLOOR = 16, LIM = 15, GSH = 2, MAXON = 192;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] ctrl_word, ss_word;
  logic [SW-1:0] isense;
  logic          gate_off;
  logic [DW-1:0] dead_cfg;
  logic [1:0]    hs_en, ls_en;
  logic          sense_sel, sense_strobe;

  int  n_chk = 0, n_bad = 0;
  int  i1 = 0, i2 = 0;
  bit  armed = 0, exp_blank = 0;
  int  q1[$], q2[$];

  always #2 clk = ~clk;

  dual_phase_pwm u_dual_phase_pwm (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ss_word(ss_word),
    .isense(isense), .gate_off(gate_off), .dead_cfg(dead_cfg),
    .hs_en(hs_en), .ls_en(ls_en), .sense_sel(sense_sel), .sense_strobe(sense_strobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int hs_expect(input int eff, input int ofs, input int dead);
    int n;
    n = eff - FLOOR - ofs;
    if (n < 0) n = 0;
    if (n > MAXON) n = MAXON;
    n = n - dead - 1;
    return (n < 0) ? 0 : n;
  endfunction

  // Sensor model: presents the current of the selected phase.
  initial begin
    isense = '0;
    forever begin
      @(negedge clk);
      isense = sense_sel ? SW'(i2) : SW'(i1);
    end
  end

  // Monitor / scoreboard
  int  hs_cnt[2], run_off[2];
  int  cyc = 0, last_stb = 0;
  bit  seen_stb = 0;
  logic last_sel = 1'b0;
  initial begin
    hs_cnt[0] = 0; hs_cnt[1] = 0; run_off[0] = 0; run_off[1] = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        for (int p = 0; p < 2; p++) begin
          if (hs_en[p]) hs_cnt[p]++;
          if (hs_en[p] || ls_en[p]) begin
            if (armed && run_off[p] > 0)
              check(run_off[p] >= int'(dead_cfg) + 1, "R9 dead time", run_off[p], int'(dead_cfg) + 1);
            run_off[p] = 0;
          end else begin
            run_off[p]++;
          end
        end
        if (sense_strobe) begin
          int p;
          p = sense_sel ? 1 : 0;
          if (p == 0 && q1.size() > 0) begin
            int e;
            e = q1.pop_front();
            check(hs_cnt[0] == e, "R2 phase-1 on-time", hs_cnt[0], e);
          end
          if (p == 1 && q2.size() > 0) begin
            int e;
            e = q2.pop_front();
            check(hs_cnt[1] == e, "R2 phase-2 on-time", hs_cnt[1], e);
          end
          hs_cnt[p] = 0;
          if (armed && !exp_blank)
            check(ls_en[p] == 1'b1, "R4 low side on at capture", int'(ls_en[p]), 1);
          if (armed && seen_stb) begin
            check(cyc - last_stb == HALF, "R1 capture spacing", cyc - last_stb, HALF);
            check(sense_sel != last_sel, "R5 select alternates", int'(sense_sel), int'(!last_sel));
          end
          seen_stb = 1;
          last_stb = cyc;
          last_sel = sense_sel;
        end
      end
    end
  end

  // Driver: applies a case, lets it settle, pushes expected on-times.
  task automatic run_case(input int c, input int s, input int a1, input int a2,
                          input bit goff, input int dead);
    int eff, d, o1, e1, e2;
    @(negedge clk);
    armed     = 0;
    ctrl_word = CW'(c);
    ss_word   = CW'(s);
    gate_off  = goff;
    dead_cfg  = DW'(dead);
    i1 = a1; i2 = a2;
    exp_blank = goff || (s < FLOOR);
    repeat (3 * PERIOD) @(negedge clk);
    eff = (c < s) ? c : s;                       // R7
    d   = a1 - a2;
    o1  = d >>> GSH;                             // R6
    if (o1 > LIM)  o1 = LIM;
    if (o1 < -LIM) o1 = -LIM;
    if (exp_blank) begin e1 = 0; e2 = 0; end     // R8
    else begin
      e1 = hs_expect(eff, o1, dead);
      e2 = hs_expect(eff, -o1, dead);
    end
    repeat (2) begin q1.push_back(e1); q2.push_back(e2); end
    armed = 1;
    while (q1.size() > 0 || q2.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctrl_word = '0; ss_word = '0; gate_off = 1'b0; dead_cfg = '0;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(hs_en == 2'b00, "R10 hs reset", int'(hs_en), 0);
    check(ls_en == 2'b00, "R10 ls reset", int'(ls_en), 0);
    check(sense_strobe == 1'b0, "R10 strobe reset", int'(sense_strobe), 0);
    check(sense_sel == 1'b1, "R10 sel reset", int'(sense_sel), 1);
    rst_n = 1'b1;

    run_case(100, 255, 50, 50, 0, 2);   // R2 balanced, R6 zero offset
    run_case(100, 255, 60, 20, 0, 2);   // R6 phase 1 heavier
    run_case(100, 255, 0, 30, 0, 2);    // R6 phase 2 heavier, rounding down
    run_case(100, 255, 200, 0, 0, 2);   // R6 clamp
    run_case(255, 255, 50, 50, 0, 2);   // R3 duty limit
    run_case(200, 80, 40, 40, 0, 2);    // R7 soft-start word lower
    run_case(60, 200, 40, 40, 0, 2);    // R7 control word lower
    run_case(200, 10, 40, 40, 0, 2);    // R8 soft-start below floor
    run_case(150, 255, 40, 40, 1, 2);   // R8 gate-off
    run_case(100, 255, 30, 30, 0, 0);   // R9 minimum dead time
    run_case(100, 255, 30, 30, 0, 7);   // R9 longer dead time
    run_case(18, 255, 30, 30, 0, 2);    // R2 demand shorter than dead time
    run_case(100, 255, 50, 50, 0, 15);  // R9 maximum dead time

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule